// File: doc/BRIEF.md
# Serial Isolation Link with Failure Watchdog

This block moves an eight-bit output-enable word across an isolation barrier. The sending side reads the parallel word and shifts it out as a framed bit stream. It starts a new frame at a fixed period, and it resends the word even when the word has not changed. The receiving side rebuilds each frame and judges it valid or invalid. A valid frame updates the parallel outputs. An invalid frame is discarded.

A failure detector on the receiving side counts rejections. A rejection is a bad frame, or a silence longer than one and a half frame periods. After four rejections in a row it switches every output off and raises `link_fail`, which feeds the diagnostic path. The first valid frame after that restores the outputs with that frame's data. The barrier itself is modelled as a one-cycle registered channel with two error injection inputs: one inverts bits and one cuts the line.

Top module: `isolink_top`

## Requirements
- R1: During and right after reset, `data_out` is 0, `link_fail` is 0 and `tx_line` is 0.
- R2: On `tx_line` each frame is 12 bit slots, each BIT_CLKS (2) cycles long, sent in this order: slot 0 = 1, slot 1 = 0, slots 2..9 = data bits 0..7 (LSB first), slot 10 = even parity over the data (XOR of the data bits), slot 11 = 1. Four 0 slots follow, giving a 32-cycle frame period. Slot 0 of the first frame goes out in the first cycle after reset. `data_in` is sampled when each frame starts.
- R3: A valid frame puts its eight data bits on `data_out`. This holds for every byte value.
- R4: The word is resent every period while `data_in` is unchanged, so a steady input never produces a rejection or a failure.
- R5: A frame whose second start slot reads 1 is rejected, and `data_out` keeps its previous value.
- R6: A frame whose parity slot does not give even parity is rejected, and `data_out` keeps its previous value.
- R7: A frame whose stop slot reads 0 is rejected, and `data_out` keeps its previous value.
- R8: Three consecutive rejections leave `data_out` and `link_fail` unchanged. The fourth forces `data_out` to 0 and sets `link_fail` to 1.
- R9: While `link_fail` is 1, the first valid frame clears `link_fail` and loads that frame's data onto `data_out`.
- R10: A valid frame resets the rejection count to zero, so three rejections, then a good frame, then three more rejections do not cause a failure.
- R11: Receiving no frame for 48 cycles (1.5 periods) counts as one rejection. A dead line therefore trips the failure after four such timeouts, and not after three.
- R12: The rejection count saturates at four. Any number of further rejections keeps the outputs off, and a single valid frame still recovers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 8 | Output-enable word on the sending side |
| chan_flip | input | 1 | Channel model: inverts the bit crossing the barrier |
| chan_cut | input | 1 | Channel model: forces the received line to 0 |
| tx_line | output | 1 | Serial line driven by the transmitter |
| data_out | output | 8 | Output-enable word on the receiving side |
| link_fail | output | 1 | High while the outputs are forced off by the watchdog |

## Verification
The bench hits one specific slot of one chosen frame with a bit inversion, covering the second start slot, the parity slot and the stop slot in turn. A receiver that skipped one of these checks would pass a corrupted byte to `data_out`. Rejection runs of exactly three and exactly four are checked, as is a good frame placed between two runs of three. An off-by-one threshold, or a counter that a good frame does not clear, would show up as a wrong `link_fail`. A dead line is tested at points between the third and fourth timeouts. This exposes a timeout window of the wrong length and a receiver that never counts silence. A long run of rejections followed by one good frame catches a counter that wraps instead of saturating.

// File: rtl/isolink_pkg.sv
package isolink_pkg;
  // Two start slots, one parity slot, one stop slot around the data.
  localparam int OVERHEAD_BITS = 4;
  // First slot sent is START_PAT[1], second is START_PAT[0].
  localparam logic [1:0] START_PAT = 2'b10;
  localparam logic STOP_LVL = 1'b1;

  typedef enum logic [1:0] {
    RX_HUNT  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_TAIL  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/isolink_tx.sv
module isolink_tx #(
  parameter int DATA_W   = 8,
  parameter int BIT_CLKS = 2,
  parameter int GAP_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_in,
  output logic              tx_line
);
  import isolink_pkg::*;

  localparam int FRAME_BITS = DATA_W + OVERHEAD_BITS;
  localparam int SLOTS      = FRAME_BITS + GAP_BITS;
  localparam int SW         = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam int IW         = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SW-1:0]         sub_q;
  logic [IW-1:0]         slot_q;
  logic [FRAME_BITS-1:0] held_q;
  logic [FRAME_BITS-1:0] frame_c;
  logic [SLOTS-1:0]      slot_bits_c;
  logic                  frame_start_c;

  assign frame_start_c = (slot_q == '0) && (sub_q == '0);

  // Latch a fresh frame at every period start; otherwise replay the held one.
  always_comb begin
    if (frame_start_c)
      frame_c = {STOP_LVL, ^data_in, data_in, START_PAT[0], START_PAT[1]};
    else
      frame_c = held_q;
    slot_bits_c = {{GAP_BITS{1'b0}}, frame_c};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q   <= '0;
      slot_q  <= '0;
      held_q  <= '0;
      tx_line <= 1'b0;
    end else begin
      held_q  <= frame_c;
      tx_line <= slot_bits_c[slot_q];
      if (sub_q == SW'(BIT_CLKS - 1)) begin
        sub_q  <= '0;
        slot_q <= (slot_q == IW'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assert_gap_low_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(slot_q) >= IW'(FRAME_BITS)) |-> !tx_line);

  assert_second_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(slot_q) == IW'(1)) |-> !tx_line);
endmodule

// File: rtl/isolink_chan.sv
module isolink_chan (
  input  logic clk,
  input  logic rst,
  input  logic tx_line,
  input  logic flip,
  input  logic cut,
  output logic rx_line
);
  // Barrier model: one register of transit delay plus error injection.
  always_ff @(posedge clk) begin
    if (rst) rx_line <= 1'b0;
    else     rx_line <= (tx_line ^ flip) & ~cut;
  end

  assert_cut_silences_R11: assert property (@(posedge clk) disable iff (rst)
    $past(cut) |-> !rx_line);
endmodule

// File: rtl/isolink_rx.sv
module isolink_rx #(
  parameter int DATA_W   = 8,
  parameter int BIT_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  output logic              frame_done,
  output logic              frame_ok,
  output logic [DATA_W-1:0] frame_data
);
  import isolink_pkg::*;

  localparam int FRAME_BITS = DATA_W + OVERHEAD_BITS;
  localparam int SW         = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam int XW         = $clog2(FRAME_BITS);

  rx_state_e             state_q;
  logic [SW-1:0]         sub_q;
  logic [XW-1:0]         idx_q;
  logic [FRAME_BITS-1:0] shreg_q;
  logic [FRAME_BITS-1:0] nxt_c;
  logic                  sample_c;
  logic                  good_c;

  assign sample_c = (state_q == RX_SHIFT) && (sub_q == SW'(BIT_CLKS - 1));

  // Frame as it stands once the slot under the sampler is included.
  always_comb begin
    nxt_c        = shreg_q;
    nxt_c[idx_q] = rx_line;
    good_c = (nxt_c[0] == START_PAT[1]) &&
             (nxt_c[1] == START_PAT[0]) &&
             !(^nxt_c[FRAME_BITS-2:2]) &&
             (nxt_c[FRAME_BITS-1] == STOP_LVL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= RX_HUNT;
      sub_q      <= '0;
      idx_q      <= '0;
      shreg_q    <= '0;
      frame_done <= 1'b0;
      frame_ok   <= 1'b0;
      frame_data <= '0;
    end else begin
      frame_done <= 1'b0;
      case (state_q)
        RX_HUNT: begin
          if (rx_line) begin
            shreg_q <= {{(FRAME_BITS-1){1'b0}}, 1'b1};
            idx_q   <= XW'(1);
            sub_q   <= '0;
            state_q <= RX_SHIFT;
          end
        end
        RX_SHIFT: begin
          if (sample_c) begin
            sub_q   <= '0;
            shreg_q <= nxt_c;
            if (idx_q == XW'(FRAME_BITS - 1)) begin
              frame_done <= 1'b1;
              frame_ok   <= good_c;
              frame_data <= nxt_c[2 +: DATA_W];
              state_q    <= RX_TAIL;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        RX_TAIL: begin
          // Wait for the idle level so the rest of the stop slot is not a start.
          if (!rx_line) state_q <= RX_HUNT;
        end
        default: state_q <= RX_HUNT;
      endcase
    end
  end

  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  assert_ok_needs_stop_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_done && frame_ok) |-> $past(rx_line));
endmodule

// File: rtl/isolink_fail.sv
module isolink_fail #(
  parameter int DATA_W     = 8,
  parameter int FAIL_LIMIT = 4,
  parameter int TMO        = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done,
  input  logic              frame_ok,
  input  logic [DATA_W-1:0] frame_data,
  output logic [DATA_W-1:0] data_out,
  output logic              link_fail
);
  localparam int CW = $clog2(FAIL_LIMIT + 1);
  localparam int TW = $clog2(TMO);

  logic [CW-1:0] cnt_q;
  logic [TW-1:0] tmr_q;
  logic          tmo_c;
  logic          reject_c;

  assign tmo_c    = (tmr_q == TW'(TMO - 1));
  assign reject_c = frame_done ? !frame_ok : tmo_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      tmr_q     <= '0;
      data_out  <= '0;
      link_fail <= 1'b0;
    end else begin
      if (frame_done || tmo_c) tmr_q <= '0;
      else                     tmr_q <= tmr_q + 1'b1;

      if (frame_done && frame_ok) begin
        cnt_q     <= '0;
        data_out  <= frame_data;
        link_fail <= 1'b0;
      end else if (reject_c) begin
        if (cnt_q != CW'(FAIL_LIMIT)) cnt_q <= cnt_q + 1'b1;
        if (cnt_q >= CW'(FAIL_LIMIT - 1)) begin
          link_fail <= 1'b1;
          data_out  <= '0;
        end
      end
    end
  end

  assert_off_while_fail_R8: assert property (@(posedge clk) disable iff (rst)
    link_fail |-> (data_out == '0));

  assert_trip_at_limit_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(link_fail) |-> ($past(cnt_q) == CW'(FAIL_LIMIT - 1)));

  assert_recover_R9: assert property (@(posedge clk) disable iff (rst)
    (frame_done && frame_ok) |=> (!link_fail && data_out == $past(frame_data)));

  assert_cnt_sat_R12: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(FAIL_LIMIT));

  assert_tmr_bound_R11: assert property (@(posedge clk) disable iff (rst)
    tmr_q < TW'(TMO));
endmodule

// File: rtl/isolink_top.sv
module isolink_top #(
  parameter int DATA_W     = 8,
  parameter int BIT_CLKS   = 2,
  parameter int GAP_BITS   = 4,
  parameter int FAIL_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_in,
  input  logic              chan_flip,
  input  logic              chan_cut,
  output logic              tx_line,
  output logic [DATA_W-1:0] data_out,
  output logic              link_fail
);
  import isolink_pkg::*;

  localparam int PERIOD = (DATA_W + OVERHEAD_BITS + GAP_BITS) * BIT_CLKS;
  localparam int TMO    = PERIOD + PERIOD / 2;

  logic              rx_line;
  logic              frame_done;
  logic              frame_ok;
  logic [DATA_W-1:0] frame_data;

  isolink_tx #(.DATA_W(DATA_W), .BIT_CLKS(BIT_CLKS), .GAP_BITS(GAP_BITS)) u_tx (
    .clk(clk), .rst(rst), .data_in(data_in), .tx_line(tx_line)
  );

  isolink_chan u_chan (
    .clk(clk), .rst(rst), .tx_line(tx_line), .flip(chan_flip),
    .cut(chan_cut), .rx_line(rx_line)
  );

  isolink_rx #(.DATA_W(DATA_W), .BIT_CLKS(BIT_CLKS)) u_rx (
    .clk(clk), .rst(rst), .rx_line(rx_line), .frame_done(frame_done),
    .frame_ok(frame_ok), .frame_data(frame_data)
  );

  isolink_fail #(.DATA_W(DATA_W), .FAIL_LIMIT(FAIL_LIMIT), .TMO(TMO)) u_fail (
    .clk(clk), .rst(rst), .frame_done(frame_done), .frame_ok(frame_ok),
    .frame_data(frame_data), .data_out(data_out), .link_fail(link_fail)
  );
endmodule

// File: tb/tb_isolink_top.sv
module tb_isolink_top;
  localparam int P = 32;  // frame period in cycles
  localparam int B = 2;   // cycles per slot

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] data_in = 8'h00;
  logic       chan_flip = 1'b0;
  logic       chan_cut = 1'b0;
  logic       tx_line;
  logic [7:0] data_out;
  logic       link_fail;

  int ncyc = 0;
  int checks = 0;
  int errors = 0;
  int fr = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) if (!rst) ncyc <= ncyc + 1;

  isolink_top #(.DATA_W(8), .BIT_CLKS(B), .GAP_BITS(4), .FAIL_LIMIT(4)) dut (
    .clk(clk), .rst(rst), .data_in(data_in), .chan_flip(chan_flip),
    .chan_cut(chan_cut), .tx_line(tx_line), .data_out(data_out),
    .link_fail(link_fail)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_until(input int n);
    while (ncyc < n) @(negedge clk);
  endtask

  function automatic logic slot_bit(input logic [7:0] v, input int j);
    if (j == 0)       return 1'b1;
    else if (j == 1)  return 1'b0;
    else if (j < 10)  return v[j-2];
    else if (j == 10) return ^v;
    else if (j == 11) return 1'b1;
    else              return 1'b0;
  endfunction

  // Send v in frame fr, optionally inverting slot fbit, then check outputs.
  task automatic frame(input logic [7:0] v, input int fbit, input logic [7:0] exp_out,
                       input logic exp_fail, input string req);
    wait_until(fr * P - 4);
    data_in = v;
    if (fbit >= 0) begin
      wait_until(fr * P + fbit * B + 1);
      chan_flip = 1'b1;
      wait_until(fr * P + fbit * B + B + 1);
      chan_flip = 1'b0;
    end
    wait_until(fr * P + 28);
    chk({req, " data_out"}, 32'(data_out), 32'(exp_out));
    chk({req, " link_fail"}, 32'(link_fail), 32'(exp_fail));
    fr++;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int f0;
    logic [7:0] last;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 data_out", 32'(data_out), 0);
    chk("R1 link_fail", 32'(link_fail), 0);
    chk("R1 tx_line", 32'(tx_line), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 link_fail after release", 32'(link_fail), 0);

    // R2: slot-by-slot frame format, two values of different parity
    wait_until(P - 4);
    data_in = 8'hA5;
    for (int j = 0; j < 16; j++) begin
      wait_until(P + j * B + 1);
      chk("R2 slot A5", 32'(tx_line), 32'(slot_bit(8'hA5, j)));
    end
    wait_until(3 * P - 4);
    data_in = 8'h07;
    for (int j = 0; j < 16; j++) begin
      wait_until(3 * P + j * B + 1);
      chk("R2 slot 07", 32'(tx_line), 32'(slot_bit(8'h07, j)));
    end

    // R3: every byte value crosses the link
    fr = 4;
    for (int v = 0; v < 256; v++) frame(8'(v), -1, 8'(v), 1'b0, "R3 sweep");

    // R4: unchanged input keeps being resent, no failure
    for (int k = 0; k < 8; k++) frame(8'hFF, -1, 8'hFF, 1'b0, "R4 steady");

    // R5, R6, R7: single corrupted frames are discarded
    frame(8'h11, 1, 8'hFF, 1'b0, "R5 start");
    frame(8'h5A, -1, 8'h5A, 1'b0, "R10 clear");
    frame(8'h22, 10, 8'h5A, 1'b0, "R6 parity");
    frame(8'h5B, -1, 8'h5B, 1'b0, "R10 clear");
    frame(8'h33, 11, 8'h5B, 1'b0, "R7 stop");
    frame(8'h5C, -1, 8'h5C, 1'b0, "R10 clear");

    // R8: three rejections hold, the fourth trips
    frame(8'h61, 10, 8'h5C, 1'b0, "R8 reject1");
    frame(8'h62, 11, 8'h5C, 1'b0, "R8 reject2");
    frame(8'h63, 1, 8'h5C, 1'b0, "R8 reject3");
    frame(8'h64, 10, 8'h00, 1'b1, "R8 reject4");

    // R12: further rejections keep outputs off; one good frame recovers
    for (int k = 0; k < 6; k++) frame(8'h70, 10, 8'h00, 1'b1, "R12 saturated");
    frame(8'h77, -1, 8'h77, 1'b0, "R9 recover");

    // R10: good frame between two runs of three rejections
    frame(8'h81, 10, 8'h77, 1'b0, "R10 run1");
    frame(8'h82, 10, 8'h77, 1'b0, "R10 run1");
    frame(8'h83, 10, 8'h77, 1'b0, "R10 run1");
    frame(8'h88, -1, 8'h88, 1'b0, "R10 good");
    frame(8'h84, 10, 8'h88, 1'b0, "R10 run2");
    frame(8'h85, 11, 8'h88, 1'b0, "R10 run2");
    frame(8'h86, 1, 8'h88, 1'b0, "R10 run2");
    frame(8'h8F, -1, 8'h8F, 1'b0, "R10 good");

    // R11: dead line, timeouts every 48 cycles after the last good frame
    f0 = fr - 1;
    last = 8'h8F;
    chan_cut = 1'b1;
    wait_until(f0 * P + 200);
    chk("R11 three timeouts data_out", 32'(data_out), 32'(last));
    chk("R11 three timeouts link_fail", 32'(link_fail), 0);
    wait_until(f0 * P + 230);
    chk("R11 four timeouts data_out", 32'(data_out), 0);
    chk("R11 four timeouts link_fail", 32'(link_fail), 1);
    wait_until((f0 + 8) * P - 6);
    chan_cut = 1'b0;
    fr = f0 + 8;
    frame(8'h99, -1, 8'h99, 1'b0, "R9 after timeout");
    frame(8'h3C, -1, 8'h3C, 1'b0, "R3 after recovery");

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule